// File: doc/BRIEF.md
# FIFO with Timed Write Port

This block is a single-clock first-in first-out buffer whose write side does not simply fail when the buffer is full. A writer raises a request with a data word and a signed timeout counted in clock cycles. If a slot is free, the word is stored at once. If not, the write may give up on the spot (timeout zero), hold on for a bounded number of cycles (timeout positive), or hold on with no limit (timeout negative). Each request ends with a one-cycle `wr_done` pulse, and `wr_timed_out` tells whether the word was dropped.

The read side is a plain pop port. A pop strobe on a non-empty buffer moves the head word to `rd_data` on the next cycle. A synchronous clear empties the storage and cancels a waiting write. Depth, word width and timeout width are parameters.

Top module: `timed_wr_fifo`

## Requirements
- R1: A request accepted while the buffer is not full stores `wr_data`. In the following cycle, `wr_done` is 1 with `wr_timed_out` 0. Words leave in the order they were stored.
- R2: A request with timeout 0 that meets a full buffer with no pop in the same cycle gives `wr_done`=1 and `wr_timed_out`=1 in the next cycle. `wr_busy` stays 0 throughout.
- R3: A request with timeout N>0 that meets a full buffer makes one attempt in the request cycle and waits N further cycles with `wr_busy`=1. If no space appears, `wr_done` and `wr_timed_out` are 1 in the cycle after the last waiting cycle.
- R4: A request with a negative timeout that meets a full buffer waits with no limit. It never ends with `wr_timed_out`=1.
- R5: A waiting write stores its held word in the first cycle that the buffer is not full. A pop in the same cycle also counts as freeing a slot. `wr_done`=1 and `wr_timed_out`=0 follow one cycle later.
- R6: A write that times out stores nothing. `count` changes only by the pops made meanwhile.
- R7: `count` gives the occupancy. `empty` is 1 exactly when `count` is 0, and `full` is 1 exactly when `count` equals DEPTH.
- R8: `clear` wins over a pop and a write in the same cycle. In the next cycle, `count` is 0 and `rd_data` is unchanged. A waiting write, or a request raised in the clear cycle, ends with `wr_done`=1, `wr_timed_out`=0 and nothing stored.
- R9: A request raised while `wr_busy` is 1 is ignored.
- R10: A pop while `empty` is 1 is ignored. `rd_data` and `count` keep their values.
- R11: A pop on a non-empty buffer places the head word on `rd_data` in the next cycle and lowers `count` by one, unless a write is stored in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clear | input | 1 | Empty the buffer and cancel a waiting write |
| wr_req | input | 1 | Write request, sampled when `wr_busy` is 0 |
| wr_data | input | DATA_W | Word to store |
| wr_timeout | input | TO_W | Signed wait limit in cycles: 0 none, negative unlimited |
| wr_busy | output | 1 | A write is waiting for space |
| wr_done | output | 1 | One-cycle end-of-request pulse |
| wr_timed_out | output | 1 | With `wr_done`: word was dropped |
| rd_en | input | 1 | Pop strobe |
| rd_data | output | DATA_W | Popped word, valid the cycle after the pop |
| empty | output | 1 | Buffer holds no word |
| full | output | 1 | Buffer holds DEPTH words |
| count | output | $clog2(DEPTH)+1 | Occupancy |

## Verification
The hardest case is a waiting write that finishes in the same cycle as a pop on a full buffer. In that cycle the head leaves, the held word enters the slot that was just vacated, and `count` stays at DEPTH. The bench reaches it by filling a small buffer, starting waits with unlimited and short timeouts, and timing a pop at a chosen offset. Random traffic then adds pops, requests raised during waits and rare clears around the waiting window. A cycle model in the bench predicts every port on every cycle.

// File: rtl/timed_wr_fifo.sv
module timed_wr_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int TO_W   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   wr_req,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic signed [TO_W-1:0] wr_timeout,
  output logic                   wr_busy,
  output logic                   wr_done,
  output logic                   wr_timed_out,
  input  logic                   rd_en,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   empty,
  output logic                   full,
  output logic [$clog2(DEPTH):0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic [CW-1:0]     cnt;
  logic              waiting, no_limit;
  logic [TO_W-1:0]   left;
  logic [DATA_W-1:0] held;

  assign count   = cnt;
  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign wr_busy = waiting;

  wire rd_fire   = rd_en && !empty && !clear;
  wire room      = !full || rd_fire;
  wire take      = wr_req && !waiting;
  wire push      = !clear && room && (waiting || take);
  wire give_up   = !clear && !room &&
                   ((take && wr_timeout == '0) ||
                    (waiting && !no_limit && left == TO_W'(1)));
  wire [DATA_W-1:0] push_word = waiting ? held : wr_data;
  wire ends      = clear ? (waiting || take) : (push || give_up);

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      rd_data <= '0;
    end else if (clear) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (rd_fire) begin
        rptr    <= rptr + 1'b1;
        rd_data <= mem[rptr];
      end
      cnt <= cnt + CW'(push) - CW'(rd_fire);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting      <= 1'b0;
      no_limit     <= 1'b0;
      left         <= '0;
      held         <= '0;
      wr_done      <= 1'b0;
      wr_timed_out <= 1'b0;
    end else begin
      wr_done      <= ends;
      wr_timed_out <= give_up;
      if (clear || (waiting && ends)) begin
        waiting <= 1'b0;
      end else if (waiting) begin
        if (!no_limit) left <= left - 1'b1;
      end else if (take && !ends) begin
        waiting  <= 1'b1;
        left     <= wr_timeout;
        no_limit <= wr_timeout[TO_W-1];
        held     <= wr_data;
      end
    end
  end

  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  p_zero_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_busy && wr_timeout == '0) |=> (!wr_busy && wr_done));

  p_unlimited_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_busy && no_limit) |=> !(wr_done && wr_timed_out));

  p_drop_keeps_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && wr_timed_out) |->
      count == $past(count) - CW'($past(rd_en && !empty && !clear)));

  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (empty && !wr_busy && !wr_timed_out && $stable(rd_data)));

  p_empty_pop_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty) |=> $stable(rd_data));

  p_busy_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_busy && !no_limit && !clear && full && !rd_en && left > TO_W'(1)) |=> wr_busy);
endmodule

// File: tb/timed_wr_fifo_tb.sv
module timed_wr_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int DEP = 4;
  localparam int TW = 8;

  logic clk = 0, rst_n = 0;
  logic clr = 0, req = 0, rd = 0;
  logic [DW-1:0] wd = '0;
  logic signed [TW-1:0] to = '0;
  logic busy, done, tout, emp, ful;
  logic [DW-1:0] rdat;
  logic [$clog2(DEP):0] cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  timed_wr_fifo #(.DATA_W(DW), .DEPTH(DEP), .TO_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clear(clr), .wr_req(req), .wr_data(wd),
    .wr_timeout(to), .wr_busy(busy), .wr_done(done), .wr_timed_out(tout),
    .rd_en(rd), .rd_data(rdat), .empty(emp), .full(ful), .count(cnt));

  int checks = 0, errors = 0;
  int q[$];
  bit mb = 0, minf = 0, edone = 0, eto = 0;
  int mrem = 0, mdata = 0, erd = 0;
  string etag = "R1", ctag = "R7", rtag = "R11";

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(ctag, "count", int'(cnt), q.size());
    chk("R7", "empty", int'(emp), int'(q.size() == 0));
    chk("R7", "full", int'(ful), int'(q.size() == DEP));
    chk("R9", "busy", int'(busy), int'(mb));
    chk(etag, "done", int'(done), int'(edone));
    chk(etag, "timed_out", int'(tout), int'(eto));
    chk(rtag, "rd_data", int'(rdat), erd);
  endtask

  function automatic void model(bit r, int d, int t, bit p, bit c);
    bit fire, room;
    edone = 0; eto = 0; ctag = "R7"; rtag = "R11";
    if (c) begin
      if (mb || r) begin edone = 1; etag = "R8"; end
      q.delete(); mb = 0; ctag = "R8"; rtag = "R8";
      return;
    end
    fire = p && q.size() > 0;
    if (p && !fire) rtag = "R10";
    room = q.size() < DEP || fire;
    if (fire) erd = q.pop_front();
    if (mb) begin
      if (room) begin q.push_back(mdata); edone = 1; mb = 0; etag = minf ? "R4" : "R5"; end
      else if (!minf && mrem == 1) begin edone = 1; eto = 1; mb = 0; etag = "R3"; ctag = "R6"; end
      else if (!minf) mrem--;
    end else if (r) begin
      if (room) begin q.push_back(d); edone = 1; etag = "R1"; end
      else if (t == 0) begin edone = 1; eto = 1; etag = "R2"; ctag = "R6"; end
      else begin mb = 1; mrem = t; minf = t < 0; mdata = d; end
    end
  endfunction

  task automatic step(bit r, int d, int t, bit p, bit c);
    compare();
    req = r; wd = DW'(d); to = TW'(t); rd = p; clr = c;
    model(r, d, t, p, c);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 fill, R7 flags
    for (int i = 0; i < DEP; i++) step(1, 16 + i, 0, 0, 0);
    idle(1);
    // R2 zero timeout on full
    step(1, 99, 0, 0, 0); idle(2);
    // R3 bounded wait expires, R6 nothing stored; R9 request ignored while busy
    step(1, 77, 3, 0, 0); step(1, 55, 0, 0, 0); idle(5);
    // R4 unlimited wait, R5 completes with same-cycle pop
    step(1, 88, -1, 0, 0); idle(12); step(0, 0, 0, 1, 0); idle(3);
    // R5 bounded wait rescued by pop in last waiting cycle
    step(1, 66, 2, 0, 0); idle(1); step(0, 0, 0, 1, 0); idle(2);
    // R8 clear cancels waiting write
    step(1, 44, -1, 0, 0); idle(3); step(1, 0, 0, 1, 1); idle(2);
    // R10 pop on empty
    step(0, 0, 0, 1, 0); step(0, 0, 0, 1, 0); idle(1);
    // R11 drain in order
    for (int i = 0; i < 3; i++) step(1, 200 + i, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0);
    idle(2);
    for (int i = 0; i < 4000; i++) begin
      int t;
      case ($urandom % 8)
        0: t = -1;
        1, 2: t = 0;
        default: t = int'($urandom % 6);
      endcase
      step(($urandom % 2) == 0, int'($urandom % 256), t,
           ($urandom % 5) < 2, ($urandom % 97) == 0);
    end
    idle(2);
    compare();
    finish_run();
  end
endmodule